// File: doc/BRIEF.md
# Two-Direction Latch/Register Bus Channel

This block carries a data word between two sides, A and B, with separate paths for A-to-B and B-to-A. Each path has one storage element. It behaves as a transparent latch while that path's open control is high. When the open control is low, the element becomes an edge-triggered register: it loads on a rising edge of the path's data clock, but only if that path's active-low clock gate is low. The outputs have no true three-state drivers. Each path drives a data bus and an enable flag instead, and an active-low drive control clears the flag. All logic runs on one system clock, and the data-clock pins are synchronized to it.

Each path is handled by one lane, and each lane holds a two-state controller. In state `LANE_PASS` the lane follows its input. In state `LANE_HOLD` it keeps its value, and it reloads only on a qualified clock edge. The transition "close" (`LANE_PASS` to `LANE_HOLD`) happens when the open control is sampled low. The transition "open" (`LANE_HOLD` to `LANE_PASS`) happens when it is sampled high. Reset puts both lanes in `LANE_PASS`.

Top module: `duplex_latch_channel`

## Requirements
- R1: While a path's open control is high, its output bus equals the input word sampled at the previous system-clock edge (one cycle of latency).
- R2: While the open control is low and no qualified clock edge occurs, the output bus holds its value, whatever the input data does.
- R3: In state `LANE_HOLD` with the clock gate low, a rising edge on the data-clock pin loads the input word. The edge passes through a two-flop synchronizer, so the new value is on the output no later than four system cycles after the pin rises.
- R4: While the clock gate is high, rising edges of the data clock leave the stored value unchanged.
- R5: While the drive control is high, the enable flag is low from the next cycle on. The stored value is kept, and it reappears with the flag when drive returns low.
- R6: The open control has priority. While it is high, a data-clock edge has no effect and the output keeps following the input.
- R7: When the open control falls, the lane keeps the word it saw in the last cycle the control was high. A clock edge detected in the closing cycle itself is ignored.
- R8: A falling edge of the data clock never changes the stored value.
- R9: The two paths are independent. Each path uses only its own controls, and both can run at the same time in different modes.
- R10: A synchronous reset clears both stored words to zero and clears both enable flags, whatever the drive controls are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 18 | A-side word into the A-to-B path |
| b_i | input | 18 | B-side word into the B-to-A path |
| ab_drive_n | input | 1 | A-to-B drive control, active low |
| ab_open | input | 1 | A-to-B open (transparent) control |
| ab_dclk | input | 1 | A-to-B data clock, asynchronous |
| ab_gate_n | input | 1 | A-to-B clock gate, active low |
| ba_drive_n | input | 1 | B-to-A drive control, active low |
| ba_open | input | 1 | B-to-A open (transparent) control |
| ba_dclk | input | 1 | B-to-A data clock, asynchronous |
| ba_gate_n | input | 1 | B-to-A clock gate, active low |
| b_o | output | 18 | Word driven toward B |
| b_en | output | 1 | B-side drive flag |
| a_o | output | 18 | Word driven toward A |
| a_en | output | 1 | A-side drive flag |

## Verification
Data is first sent through an open lane with two different words, which shows that the lane follows its input and does not latch once. A close during steady inputs, and data changes after the close, tell the R7 hold apart from the R1 follow. Rising and falling data-clock edges are applied with the gate low and then with it high, which separates a genuine capture from gating and from a wrong-edge capture. A final pattern runs both paths at once in different modes, with distinct words, to expose any crossed controls.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    localparam int DLC_WORD = 18;
    localparam int DLC_SYNC = 2;

    typedef enum logic {
        LANE_PASS = 1'b0,
        LANE_HOLD = 1'b1
    } lane_state_t;
endpackage

// File: rtl/dlc_edge_sync.sv
module dlc_edge_sync #(
    parameter int STAGES = dlc_pkg::DLC_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], pin_i};
    end

    assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/dlc_lane.sv
module dlc_lane
    import dlc_pkg::*;
#(
    parameter int WIDTH = DLC_WORD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din_i,
    input  logic             open_i,
    input  logic             rise_i,
    input  logic             gate_n_i,
    input  logic             drive_n_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             en_o
);
    lane_state_t state_q, state_d;
    logic [WIDTH-1:0] word_q, word_d;
    logic load_edge;
    logic en_q;

    // controller: close when open falls, open when it rises
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_PASS: if (!open_i) state_d = LANE_HOLD;
            LANE_HOLD: if (open_i)  state_d = LANE_PASS;
            default:   state_d = LANE_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LANE_PASS;
        else     state_q <= state_d;
    end

    // an edge only counts once the lane was already closed
    assign load_edge = (state_q == LANE_HOLD) && rise_i && !gate_n_i;

    always_comb begin
        word_d = word_q;
        unique case (state_d)
            LANE_PASS: word_d = din_i;
            LANE_HOLD: if (load_edge) word_d = din_i;
            default:   word_d = word_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            en_q   <= 1'b0;
        end else begin
            word_q <= word_d;
            en_q   <= ~drive_n_i;
        end
    end

    assign dout_o = word_q;
    assign en_o   = en_q;

    assert_follow_R1: assert property (@(posedge clk) disable iff (rst)
        open_i |=> dout_o == $past(din_i));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!open_i && !(rise_i && !gate_n_i)) |=> $stable(dout_o));
    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (!open_i && !$past(open_i) && rise_i && !gate_n_i) |=> dout_o == $past(din_i));
    assert_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (!open_i && gate_n_i) |=> $stable(dout_o));
    assert_drive_off_R5: assert property (@(posedge clk) disable iff (rst)
        drive_n_i |=> !en_o);
    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (dout_o == '0) && !en_o);
endmodule

// File: rtl/duplex_latch_channel.sv
module duplex_latch_channel
    import dlc_pkg::*;
#(
    parameter int WIDTH  = DLC_WORD,
    parameter int STAGES = DLC_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             ab_drive_n,
    input  logic             ab_open,
    input  logic             ab_dclk,
    input  logic             ab_gate_n,
    input  logic             ba_drive_n,
    input  logic             ba_open,
    input  logic             ba_dclk,
    input  logic             ba_gate_n,
    output logic [WIDTH-1:0] b_o,
    output logic             b_en,
    output logic [WIDTH-1:0] a_o,
    output logic             a_en
);
    logic ab_rise, ba_rise;

    dlc_edge_sync #(.STAGES(STAGES)) u_ab_sync (
        .clk(clk), .rst(rst), .pin_i(ab_dclk), .rise_o(ab_rise));

    dlc_edge_sync #(.STAGES(STAGES)) u_ba_sync (
        .clk(clk), .rst(rst), .pin_i(ba_dclk), .rise_o(ba_rise));

    dlc_lane #(.WIDTH(WIDTH)) u_ab_lane (
        .clk(clk), .rst(rst), .din_i(a_i), .open_i(ab_open),
        .rise_i(ab_rise), .gate_n_i(ab_gate_n), .drive_n_i(ab_drive_n),
        .dout_o(b_o), .en_o(b_en));

    dlc_lane #(.WIDTH(WIDTH)) u_ba_lane (
        .clk(clk), .rst(rst), .din_i(b_i), .open_i(ba_open),
        .rise_i(ba_rise), .gate_n_i(ba_gate_n), .drive_n_i(ba_drive_n),
        .dout_o(a_o), .en_o(a_en));
endmodule

// File: tb/sim_duplex_latch_channel.sv
module sim_duplex_latch_channel;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic ab_drive_n = 1'b0, ab_open = 1'b0, ab_dclk = 1'b0, ab_gate_n = 1'b1;
    logic ba_drive_n = 1'b0, ba_open = 1'b0, ba_dclk = 1'b0, ba_gate_n = 1'b1;
    logic [W-1:0] b_o, a_o;
    logic b_en, a_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    duplex_latch_channel u0 (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
        .ab_drive_n(ab_drive_n), .ab_open(ab_open), .ab_dclk(ab_dclk), .ab_gate_n(ab_gate_n),
        .ba_drive_n(ba_drive_n), .ba_open(ba_open), .ba_dclk(ba_dclk), .ba_gate_n(ba_gate_n),
        .b_o(b_o), .b_en(b_en), .a_o(a_o), .a_en(a_en));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        step(3);
        check("R10 b_o after reset", b_o, '0);
        check("R10 b_en after reset", {17'd0, b_en}, '0);
        check("R10 a_o after reset", a_o, '0);
        check("R10 a_en after reset", {17'd0, a_en}, '0);
        rst = 1'b0;
        step(2);
        check("R5 b_en with drive low", {17'd0, b_en}, 18'd1);
    endtask

    task automatic t_follow;
        ab_open = 1'b1; a_i = 18'h2A5A5; step(2);
        check("R1 follow pattern 1", b_o, 18'h2A5A5);
        a_i = 18'h15A5A; step(2);
        check("R1 follow pattern 2", b_o, 18'h15A5A);
    endtask

    task automatic t_close;
        a_i = 18'h01234; step(2);
        ab_open = 1'b0; a_i = 18'h3FFFF; step(3);
        check("R7 keeps last open word", b_o, 18'h01234);
        a_i = 18'h00F0F; step(3);
        check("R2 hold while data changes", b_o, 18'h01234);
    endtask

    task automatic t_capture;
        ab_gate_n = 1'b0; step(3);
        a_i = 18'h2BEEF; ab_dclk = 1'b1; step(5);
        check("R3 capture on rising edge", b_o, 18'h2BEEF);
        a_i = 18'h10101; step(5);
        check("R2 hold with clock high", b_o, 18'h2BEEF);
        ab_dclk = 1'b0; step(5);
        check("R8 falling edge ignored", b_o, 18'h2BEEF);
    endtask

    task automatic t_gate;
        ab_gate_n = 1'b1; a_i = 18'h0C0DE; ab_dclk = 1'b1; step(5);
        check("R4 gated edge ignored", b_o, 18'h2BEEF);
        ab_dclk = 1'b0; step(3);
    endtask

    task automatic t_priority;
        ab_gate_n = 1'b0; ab_open = 1'b1; a_i = 18'h22222; ab_dclk = 1'b1; step(2);
        a_i = 18'h33333; step(4);
        check("R6 open overrides edge", b_o, 18'h33333);
        ab_dclk = 1'b0; step(3);
    endtask

    task automatic t_drive;
        ab_open = 1'b0; step(2);
        ab_drive_n = 1'b1; a_i = 18'h00001; step(2);
        check("R5 flag off", {17'd0, b_en}, '0);
        check("R9 other flag untouched", {17'd0, a_en}, 18'd1);
        ab_drive_n = 1'b0; step(2);
        check("R5 flag back", {17'd0, b_en}, 18'd1);
        check("R5 word kept", b_o, 18'h33333);
    endtask

    task automatic t_both;
        ab_open = 1'b1; ab_gate_n = 1'b1;
        ba_open = 1'b0; ba_gate_n = 1'b0; step(3);
        a_i = 18'h1AAAA; b_i = 18'h05555; ba_dclk = 1'b1; step(5);
        check("R9 A-to-B transparent", b_o, 18'h1AAAA);
        check("R9 B-to-A captured", a_o, 18'h05555);
        b_i = 18'h3CCCC; a_i = 18'h03333; step(3);
        check("R9 B-to-A holds", a_o, 18'h05555);
        check("R9 A-to-B follows", b_o, 18'h03333);
    endtask

    initial begin
        step(1);
        t_reset;
        t_follow;
        t_close;
        t_capture;
        t_gate;
        t_priority;
        t_drive;
        t_both;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule